// File: doc/BRIEF.md
# Serial Audio Link Downstream Frame Receiver

This block sits on the codec side of a fixed-rate, bit-clocked audio link and turns the controller's serial stream into parallel, per-frame events. A rising edge on the frame-sync input marks the start of a frame. Each frame has a 16-bit tag slot and then twelve 20-bit slots. The block samples the serial data line on the falling edge of the bit clock, reads the validity flags from the tag, and extracts two things from the slots after it. The first is a control request: a read or write command, a 7-bit register index and 16-bit write data. The second is a pair of 18-bit playback samples for the left and right converters.

Each extracted item is presented with a one-cycle strobe. A register file uses the control strobes and the converter ports use the sample strobes. Frames run at 256 bit clocks. Slots 5 through 12 carry nothing the block uses. After the 256th bit the receiver stays idle until the next frame-sync rise, and a rise in mid-frame restarts the framing at once.

Top module: `acl_out_rx`

## Requirements
- R1: After reset every strobe is low and every data output is zero. No strobe fires before the first rising edge of `frame_sync` is sampled, whatever `ser_data` carries.
- R2: The falling edge that first samples `frame_sync` high is frame bit -1. The next falling edge samples frame bit 0. Bits are taken MSB first: tag bits 15..0 are frame bits 0..15, and slot k (1..12) covers frame bits 16+20(k-1) to 35+20(k-1).
- R3: When tag bit 15 (frame valid) is 0, no strobe of any kind is issued for that frame, whatever tag bits 14..11 hold.
- R4: When tag bits 15, 14 and 13 are all 1 and slot 1 bit 19 is 0 (write), `ctl_wr_stb` is high for exactly one cycle, on the falling edge that samples frame bit 55. With it, `ctl_addr` equals slot 1 bits 18:12 and `ctl_wdata` equals slot 2 bits 19:4.
- R5: When tag bits 15 and 14 are 1 and slot 1 bit 19 is 1 (read), `ctl_rd_stb` is high for one cycle on the same edge, with `ctl_addr` equal to slot 1 bits 18:12. The state of tag bit 13 and the contents of slot 2 have no effect on it.
- R6: A write request whose tag bit 13 (data valid) is 0 produces neither a write strobe nor a read strobe, and `ctl_addr` and `ctl_wdata` keep their values.
- R7: When tag bits 15 and 12 are 1, `pcm_l_stb` is high for one cycle on the edge that samples frame bit 75, and `pcm_l` equals slot 3 bits 19:2. At all other times `pcm_l` holds its value.
- R8: When tag bits 15 and 11 are 1, `pcm_r_stb` is high for one cycle on the edge that samples frame bit 95, and `pcm_r` equals slot 4 bits 19:2. At all other times `pcm_r` holds its value.
- R9: Tag bits 10..0, slot 1 bits 11:0, slot 2 bits 3:0, bits 1:0 of slots 3 and 4, and all of slots 5 through 12 have no effect on any output.
- R10: A `frame_sync` rise before a frame ends abandons that frame: slots it had not yet completed produce no strobe. After frame bit 255, serial data is ignored until the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock; inputs are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_sync | input | 1 | Frame marker; a low-to-high change begins a frame |
| ser_data | input | 1 | Serial data from the controller, MSB first |
| ctl_wr_stb | output | 1 | One-cycle register write request |
| ctl_rd_stb | output | 1 | One-cycle register read request |
| ctl_addr | output | 7 | Register index of the latest request |
| ctl_wdata | output | 16 | Write data of the latest write request |
| pcm_l_stb | output | 1 | One-cycle left sample strobe |
| pcm_l | output | 18 | Latest left playback sample |
| pcm_r_stb | output | 1 | One-cycle right sample strobe |
| pcm_r | output | 18 | Latest right playback sample |

## Verification
The stimulus covers several frame types, and each one separates a different kind of error. Full write and read frames check slot boundaries and field positions. A frame with the frame-valid bit cleared but every slot flag set shows whether frame-valid gating is applied. A write with the data flag missing, and a read whose data slot is full of ones, show whether the command decode takes the right flags. Frames whose reserved bits and reserved slots are all ones, and samples at all-ones and all-zeros, expose slices that are off by a bit or that pick up neighbouring bits. Frames cut short at bit 60 and bit 30, and garbage sent with sync low after a frame, show whether the receiver restarts and idles correctly.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;

  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } ctl_cmd_e;

  typedef struct packed {
    logic frame_ok;
    logic addr_ok;
    logic data_ok;
    logic left_ok;
    logic right_ok;
  } tag_flags_t;

  // Frame bit index at which slot k finishes (slot 0 is the tag slot).
  function automatic int slot_last_bit(int k, int tag_bits, int slot_bits);
    return (k == 0) ? (tag_bits - 1) : (tag_bits + slot_bits * k - 1);
  endfunction

endpackage

// File: rtl/acl_frame_timer.sv
module acl_frame_timer
  import acl_rx_pkg::*;
#(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int DATA_SLOTS = 12,
  parameter int N_ENDS     = 5
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  output logic              take_bit,
  output logic [N_ENDS-1:0] slot_end
);

  localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * DATA_SLOTS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int LAST_IDX   = FRAME_BITS - 1;

  logic             sync_q;
  logic             run_q, run_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sync_rise;
  logic             idx_en;

  assign sync_rise = frame_sync & ~sync_q;
  assign take_bit  = run_q & ~sync_rise;
  assign idx_en    = sync_rise | run_q;

  always_comb begin
    run_d = run_q;
    idx_d = idx_q;
    if (sync_rise) begin
      run_d = 1'b1;
      idx_d = '0;
    end else if (run_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_W'(LAST_IDX)) run_d = 1'b0;
    end
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      run_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      sync_q <= frame_sync;
      run_q  <= run_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  for (genvar k = 0; k < N_ENDS; k++) begin : g_end
    localparam int END_IDX = slot_last_bit(k, TAG_BITS, SLOT_BITS);
    assign slot_end[k] = take_bit && (idx_q == IDX_W'(END_IDX));
  end

endmodule

// File: rtl/acl_slot_shifter.sv
module acl_slot_shifter #(
  parameter int SLOT_BITS = 20
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 ser_data,
  output logic [SLOT_BITS-1:0] word
);

  logic [SLOT_BITS-2:0] sh_q, sh_d;

  // The word completes on the edge that samples its final bit.
  assign word = {sh_q, ser_data};
  assign sh_d = word[SLOT_BITS-2:0];

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (shift_en) sh_q <= sh_d;
  end

endmodule

// File: rtl/acl_slot_extract.sv
module acl_slot_extract
  import acl_rx_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 18,
  parameter int N_ENDS    = 5
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic [N_ENDS-1:0]    slot_end,
  input  logic [SLOT_BITS-1:0] word,
  output logic                 ctl_wr_stb,
  output logic                 ctl_rd_stb,
  output logic [ADDR_W-1:0]    ctl_addr,
  output logic [DATA_W-1:0]    ctl_wdata,
  output logic                 pcm_l_stb,
  output logic [PCM_W-1:0]     pcm_l,
  output logic                 pcm_r_stb,
  output logic [PCM_W-1:0]     pcm_r
);

  localparam int FLAG_HI = TAG_BITS - 1;
  localparam int CMD_POS = SLOT_BITS - 1;
  localparam int ADDR_HI = SLOT_BITS - 2;
  localparam int TOP     = SLOT_BITS - 1;

  tag_flags_t        flags_q, flags_d;
  ctl_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] pend_q, pend_d;
  logic              wr_d, rd_d, l_d, r_d;
  logic              flags_en, req_en, ctl_en;
  logic              unused_word;

  assign unused_word = ^word;
  assign flags_en    = slot_end[0];
  assign req_en      = slot_end[1];
  assign ctl_en      = wr_d | rd_d;

  always_comb begin
    flags_d = flags_q;
    cmd_d   = cmd_q;
    pend_d  = pend_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    l_d     = 1'b0;
    r_d     = 1'b0;
    if (slot_end[0]) flags_d = tag_flags_t'(word[FLAG_HI -: 5]);
    if (slot_end[1]) begin
      cmd_d  = ctl_cmd_e'(word[CMD_POS]);
      pend_d = word[ADDR_HI -: ADDR_W];
    end
    if (slot_end[2]) begin
      wr_d = flags_q.frame_ok && flags_q.addr_ok && flags_q.data_ok
             && (cmd_q == CMD_WRITE);
      rd_d = flags_q.frame_ok && flags_q.addr_ok && (cmd_q == CMD_READ);
    end
    if (slot_end[3]) l_d = flags_q.frame_ok && flags_q.left_ok;
    if (slot_end[4]) r_d = flags_q.frame_ok && flags_q.right_ok;
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= '0;
      cmd_q      <= CMD_WRITE;
      pend_q     <= '0;
      ctl_wr_stb <= 1'b0;
      ctl_rd_stb <= 1'b0;
      ctl_addr   <= '0;
      ctl_wdata  <= '0;
      pcm_l_stb  <= 1'b0;
      pcm_l      <= '0;
      pcm_r_stb  <= 1'b0;
      pcm_r      <= '0;
    end else begin
      ctl_wr_stb <= wr_d;
      ctl_rd_stb <= rd_d;
      pcm_l_stb  <= l_d;
      pcm_r_stb  <= r_d;
      if (flags_en) flags_q <= flags_d;
      if (req_en) begin
        cmd_q  <= cmd_d;
        pend_q <= pend_d;
      end
      if (ctl_en) ctl_addr  <= pend_q;
      if (wr_d)   ctl_wdata <= word[TOP -: DATA_W];
      if (l_d)    pcm_l     <= word[TOP -: PCM_W];
      if (r_d)    pcm_r     <= word[TOP -: PCM_W];
    end
  end

endmodule

// File: rtl/acl_out_rx.sv
module acl_out_rx #(
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  parameter int DATA_SLOTS = 12,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int PCM_W      = 18
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              ser_data,
  output logic              ctl_wr_stb,
  output logic              ctl_rd_stb,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [DATA_W-1:0] ctl_wdata,
  output logic              pcm_l_stb,
  output logic [PCM_W-1:0]  pcm_l,
  output logic              pcm_r_stb,
  output logic [PCM_W-1:0]  pcm_r
);

  // Tag slot plus control address, control data, left and right slots.
  localparam int N_ENDS = 5;

  logic [1:0]           rst_pipe;
  logic                 rst_core_n;
  logic                 take_bit;
  logic [N_ENDS-1:0]    slot_end;
  logic [SLOT_BITS-1:0] word;

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  acl_frame_timer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS),
    .DATA_SLOTS(DATA_SLOTS), .N_ENDS(N_ENDS)
  ) u_timer (
    .bit_clk(bit_clk), .rst_n(rst_core_n), .frame_sync(frame_sync),
    .take_bit(take_bit), .slot_end(slot_end)
  );

  acl_slot_shifter #(.SLOT_BITS(SLOT_BITS)) u_shift (
    .bit_clk(bit_clk), .rst_n(rst_core_n), .shift_en(take_bit),
    .ser_data(ser_data), .word(word)
  );

  acl_slot_extract #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .PCM_W(PCM_W), .N_ENDS(N_ENDS)
  ) u_extract (
    .bit_clk(bit_clk), .rst_n(rst_core_n), .slot_end(slot_end), .word(word),
    .ctl_wr_stb(ctl_wr_stb), .ctl_rd_stb(ctl_rd_stb),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .pcm_l_stb(pcm_l_stb), .pcm_l(pcm_l),
    .pcm_r_stb(pcm_r_stb), .pcm_r(pcm_r)
  );

endmodule

// File: rtl/acl_out_rx_chk.sv
module acl_out_rx_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int PCM_W  = 18
) (
  input logic              bit_clk,
  input logic              rst_n,
  input logic              take_bit,
  input logic              ctl_wr_stb,
  input logic              ctl_rd_stb,
  input logic [ADDR_W-1:0] ctl_addr,
  input logic [DATA_W-1:0] ctl_wdata,
  input logic              pcm_l_stb,
  input logic [PCM_W-1:0]  pcm_l,
  input logic              pcm_r_stb,
  input logic [PCM_W-1:0]  pcm_r
);

  a_r4_wr_single: assert property (@(negedge bit_clk) disable iff (!rst_n)
    ctl_wr_stb |=> !ctl_wr_stb);

  a_r5_rd_single: assert property (@(negedge bit_clk) disable iff (!rst_n)
    ctl_rd_stb |=> !ctl_rd_stb);

  a_r5_rd_wr_excl: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !(ctl_wr_stb && ctl_rd_stb));

  a_r4_wdata_hold: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !$stable(ctl_wdata) |-> ctl_wr_stb);

  a_r6_addr_hold: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !$stable(ctl_addr) |-> (ctl_wr_stb || ctl_rd_stb));

  a_r7_left_hold: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !$stable(pcm_l) |-> pcm_l_stb);

  a_r8_right_hold: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !$stable(pcm_r) |-> pcm_r_stb);

  a_r10_stb_needs_bit: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (ctl_wr_stb || ctl_rd_stb || pcm_l_stb || pcm_r_stb) |-> $past(take_bit));

endmodule

bind acl_out_rx acl_out_rx_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PCM_W(PCM_W)
) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_core_n), .take_bit(take_bit),
  .ctl_wr_stb(ctl_wr_stb), .ctl_rd_stb(ctl_rd_stb),
  .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
  .pcm_l_stb(pcm_l_stb), .pcm_l(pcm_l),
  .pcm_r_stb(pcm_r_stb), .pcm_r(pcm_r)
);

// File: tb/sim_acl_out_rx.sv
`timescale 1ns/1ps
module sim_acl_out_rx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fsync;
  logic        sd;
  logic        wr_stb, rd_stb, l_stb, r_stb;
  logic [6:0]  addr;
  logic [15:0] wdata;
  logic [17:0] pl, pr;

  int checks = 0;
  int fails  = 0;
  int stb_seen = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read, 2 left, 3 right
    logic [6:0]  addr;
    logic [17:0] val;
  } ev_t;

  ev_t exp_q[$];

  always #4 clk = ~clk;

  acl_out_rx u0 (
    .bit_clk(clk), .rst_n(rst_n), .frame_sync(fsync), .ser_data(sd),
    .ctl_wr_stb(wr_stb), .ctl_rd_stb(rd_stb), .ctl_addr(addr),
    .ctl_wdata(wdata), .pcm_l_stb(l_stb), .pcm_l(pl),
    .pcm_r_stb(r_stb), .pcm_r(pr)
  );

  function automatic string req_of(logic [1:0] k);
    case (k)
      2'd0:    return "R4";
      2'd1:    return "R5";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic take(input logic [1:0] k, input logic [6:0] a, input logic [17:0] v);
    ev_t e;
    stb_seen++;
    if (exp_q.size() == 0) begin
      note(1'b0, "R10", "unexpected strobe kind", 32'(k), 32'hFFFF_FFFF);
    end else begin
      e = exp_q.pop_front();
      note(e.kind == k, req_of(e.kind), "strobe kind", 32'(k), 32'(e.kind));
      if (e.kind == k && (k == 2'd0 || k == 2'd1))
        note(a == e.addr, req_of(k), "register index", 32'(a), 32'(e.addr));
      if (e.kind == k && k != 2'd1)
        note(v == e.val, req_of(k), "data value", 32'(v), 32'(e.val));
    end
  endtask

  // Monitor: design updates on falling edges, sampled here on rising edges.
  always @(posedge clk) begin
    if (rst_n && !finished) begin
      if (wr_stb) take(2'd0, addr, {2'b00, wdata});
      if (rd_stb) take(2'd1, addr, 18'h0);
      if (l_stb)  take(2'd2, 7'h0, pl);
      if (r_stb)  take(2'd3, 7'h0, pr);
    end
  end

  // Driver: builds a frame, predicts its events, then shifts out nbits bits.
  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1,
                            input logic [19:0] s2, input logic [19:0] s3,
                            input logic [19:0] s4, input logic [19:0] rsv,
                            input int nbits);
    logic [255:0] fr;
    ev_t e;
    fr = {tag, s1, s2, s3, s4, {8{rsv}}};
    if (tag[15] && tag[14] && nbits > 55) begin
      if (!s1[19] && tag[13]) begin
        e = '{kind: 2'd0, addr: s1[18:12], val: {2'b00, s2[19:4]}};
        exp_q.push_back(e);
      end else if (s1[19]) begin
        e = '{kind: 2'd1, addr: s1[18:12], val: 18'h0};
        exp_q.push_back(e);
      end
    end
    if (tag[15] && tag[12] && nbits > 75) begin
      e = '{kind: 2'd2, addr: 7'h0, val: s3[19:2]};
      exp_q.push_back(e);
    end
    if (tag[15] && tag[11] && nbits > 95) begin
      e = '{kind: 2'd3, addr: 7'h0, val: s4[19:2]};
      exp_q.push_back(e);
    end
    @(posedge clk);
    fsync <= 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk);
      sd    <= fr[255-i];
      fsync <= (i < 15);
    end
    @(posedge clk);
    fsync <= 1'b0;
  endtask

  task automatic garbage(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      fsync <= 1'b0;
      sd    <= ((i * 7) % 3) != 0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0;
    fsync = 1'b0;
    sd    = 1'b0;
    repeat (4) @(posedge clk);
    // R1: reset values
    note({wr_stb, rd_stb, l_stb, r_stb} == 4'b0 && addr == 0 && wdata == 0
         && pl == 0 && pr == 0, "R1", "reset outputs",
         {wr_stb, rd_stb, l_stb, r_stb, addr, wdata}, 32'h0);
    @(posedge clk);
    rst_n <= 1'b1;
    // R1: data with no sync rise
    garbage(300);
    note(stb_seen == 0, "R1", "strobes before first sync", 32'(stb_seen), 32'h0);

    // R2 R4 R7 R8: full write frame
    send_frame(16'hF800, {1'b0, 7'h26, 12'h000}, {16'hA5C3, 4'h0},
               20'h12345, 20'hFEDCB, 20'h0, 256);
    // R5: read frame
    send_frame(16'hC000, {1'b1, 7'h7C, 12'h000}, 20'h0, 20'h0, 20'h0, 20'h0, 256);

    // R3: frame-valid clear with every slot flag set
    base = stb_seen;
    send_frame(16'h7FFF, {1'b0, 7'h11, 12'h0}, {16'h1234, 4'h0},
               20'hAAAAA, 20'h55555, 20'h0, 256);
    repeat (4) @(posedge clk);
    note(stb_seen == base, "R3", "strobes with frame invalid", 32'(stb_seen - base), 32'h0);

    // R6: write without data flag, left sample only
    base = stb_seen;
    send_frame(16'hD000, {1'b0, 7'h05, 12'h0}, {16'hBEEF, 4'h0},
               20'h0F0F0, 20'h33333, 20'h0, 256);
    repeat (4) @(posedge clk);
    note(stb_seen == base + 1, "R6", "strobes without data flag", 32'(stb_seen - base), 32'h1);
    note(addr == 7'h7C && wdata == 16'hA5C3, "R6", "control fields held",
         {addr, wdata}, {7'h7C, 16'hA5C3});

    // R9: ignored bits and reserved slots all ones
    send_frame(16'hF9FF, {1'b0, 7'h3A, 12'hFFF}, {16'h0F0F, 4'hF},
               20'hC0003, 20'h3FFFF, 20'hFFFFF, 256);
    // R5: read with data flag and busy data slot
    send_frame(16'hF000, {1'b1, 7'h01, 12'h0}, 20'hFFFFF, 20'h0, 20'h0, 20'h0, 256);
    // R7 R8: extreme samples
    send_frame(16'h9800, 20'h0, 20'h0, 20'hFFFFF, 20'h00000, 20'h0, 256);
    send_frame(16'h9800, 20'h0, 20'h0, 20'h00000, 20'hFFFFC, 20'h0, 256);

    // R10: cut frames, then a full one
    send_frame(16'hF800, {1'b0, 7'h44, 12'h0}, {16'h7777, 4'h0},
               20'h11111, 20'h22222, 20'h0, 60);
    send_frame(16'hF800, {1'b0, 7'h55, 12'h0}, {16'h8888, 4'h0},
               20'h33333, 20'h44444, 20'h0, 30);
    send_frame(16'hF800, {1'b0, 7'h66, 12'h0}, {16'h9999, 4'h0},
               20'h55555, 20'h66666, 20'h0, 256);
    // R10: data after frame end is ignored
    base = stb_seen;
    garbage(400);
    note(stb_seen == base, "R10", "strobes while idle", 32'(stb_seen - base), 32'h0);

    repeat (10) @(posedge clk);
    note(exp_q.size() == 0, "R2", "expected events left over", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule